// File: doc/BRIEF.md
# Sub-Field Write Integer Register File

This block holds the integer working registers of a processor core. It has sixteen 64-bit entries, one write port and two read ports. A write can cover the whole entry, the lower 32 bits, the lower 16 bits, the lowest byte, or the second byte (bits 15:8). Each write size follows its own rule for the bits it does not cover. A 32-bit write clears the upper half of the entry. A 16-bit or byte write leaves every bit outside its field as it was. The second-byte lane exists only for the first few entries. A request for that lane on any other entry is dropped and reported on a one-cycle flag.

Each read port has its own size code and returns the chosen field, zero-extended to 64 bits. A second-byte read returns bits 15:8 moved down to bits 7:0. A read of the entry being written in the same cycle sees the merged value that the write will leave behind. Decode, renaming and wide vector state are handled outside the block.

Top module: `gpr_subfield_rf`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every entry is zero and `wr_illegal` is low. After release, every read returns zero until a write lands.
- R2: Size code 3'b000 (full) replaces all 64 bits of the addressed entry at the next rising clock edge.
- R3: Size code 3'b001 (word) stores `wr_data[31:0]` in bits 31:0 and forces bits 63:32 to zero.
- R4: Size code 3'b010 (half) replaces bits 15:0 with `wr_data[15:0]` and leaves bits 63:16 unchanged.
- R5: Size code 3'b011 (low byte) replaces bits 7:0 with `wr_data[7:0]` and leaves all other bits unchanged, for every index.
- R6: Size code 3'b100 (second byte) on an index below `HB_REGS` (default 4) writes `wr_data[7:0]` into bits 15:8 and leaves all other bits unchanged. Starting from 0x1234567890ABCDEF, the write series low byte 0xFF, second byte 0xFF, half 0xBEEF, word 0 leaves 0x1234567890ABCDFF, 0x1234567890ABFFFF, 0x1234567890ABBEEF and then zero.
- R7: A second-byte write to an index at or above `HB_REGS` changes no entry, and `wr_illegal` is high for exactly the one cycle after that clock edge.
- R8: A write with size code 3'b101, 3'b110 or 3'b111 changes no entry, and `wr_illegal` is high for the one cycle after that edge.
- R9: A read with code 000/001/010/011 returns bits 63:0 / 31:0 / 15:0 / 7:0 zero-extended. Code 100 returns bits 15:8 in bits 7:0 when the index is below `HB_REGS`, and zero otherwise. Codes 101 to 111 return zero.
- R10: When a legal write targets the index a read port is reading in the same cycle, that port returns the merged post-write value.
- R11: The two read ports select index and size independently of each other.
- R12: With `wr_en` low, no entry changes and `wr_illegal` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Entry index for the write |
| wr_size | input | 3 | Write size code |
| wr_data | input | 64 | Write data, right-aligned |
| rd0_idx | input | 4 | Entry index, read port 0 |
| rd0_size | input | 3 | Read size code, port 0 |
| rd0_data | output | 64 | Read result, port 0 |
| rd1_idx | input | 4 | Entry index, read port 1 |
| rd1_size | input | 3 | Read size code, port 1 |
| rd1_data | output | 64 | Read result, port 1 |
| wr_illegal | output | 1 | One-cycle pulse after a dropped write |

## Verification
The bench builds the block with its default parameters: sixteen entries, 64-bit data and a second-byte lane on entries 0 to 3. With these values both sides of the lane boundary (indices 3 and 4) can be reached, and every size code, including the three unused ones, can be applied on both the write port and the read ports. Random traffic limited to sixteen indices makes same-cycle write/read collisions frequent. This exercises the bypass path under every merge rule, and it also exercises the case where a dropped write must not be forwarded.

// File: rtl/gpr_rf_pkg.sv
package gpr_rf_pkg;

  typedef enum logic [2:0] {
    SZ_FULL    = 3'b000,
    SZ_WORD    = 3'b001,
    SZ_HALF    = 3'b010,
    SZ_BYTE_LO = 3'b011,
    SZ_BYTE_HI = 3'b100
  } size_e;

  localparam int WORD_BITS = 32;
  localparam int HALF_BITS = 16;
  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/gpr_wr_merge.sv
module gpr_wr_merge
  import gpr_rf_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 4,
  parameter int HB_REGS = 4
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        size,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] new_val,
  output logic              legal
);

  localparam logic [IDX_W:0] HB_LIM = (IDX_W+1)'(HB_REGS);

  logic hb_lane_ok;
  assign hb_lane_ok = ({1'b0, idx} < HB_LIM);

  always_comb begin
    new_val = old_val;
    legal   = 1'b0;
    case (size)
      SZ_FULL: begin
        new_val = wdata;
        legal   = 1'b1;
      end
      SZ_WORD: begin
        new_val = {{(DATA_W-WORD_BITS){1'b0}}, wdata[WORD_BITS-1:0]};
        legal   = 1'b1;
      end
      SZ_HALF: begin
        new_val = {old_val[DATA_W-1:HALF_BITS], wdata[HALF_BITS-1:0]};
        legal   = 1'b1;
      end
      SZ_BYTE_LO: begin
        new_val = {old_val[DATA_W-1:BYTE_BITS], wdata[BYTE_BITS-1:0]};
        legal   = 1'b1;
      end
      SZ_BYTE_HI: begin
        legal = hb_lane_ok;
        if (hb_lane_ok)
          new_val = {old_val[DATA_W-1:HALF_BITS], wdata[BYTE_BITS-1:0],
                     old_val[BYTE_BITS-1:0]};
      end
      default: begin
        new_val = old_val;
        legal   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/gpr_rd_extract.sv
module gpr_rd_extract
  import gpr_rf_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 4,
  parameter int HB_REGS = 4
) (
  input  logic [DATA_W-1:0] src,
  input  logic [2:0]        size,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] field
);

  localparam logic [IDX_W:0] HB_LIM = (IDX_W+1)'(HB_REGS);

  always_comb begin
    field = '0;
    case (size)
      SZ_FULL:    field = src;
      SZ_WORD:    field = {{(DATA_W-WORD_BITS){1'b0}}, src[WORD_BITS-1:0]};
      SZ_HALF:    field = {{(DATA_W-HALF_BITS){1'b0}}, src[HALF_BITS-1:0]};
      SZ_BYTE_LO: field = {{(DATA_W-BYTE_BITS){1'b0}}, src[BYTE_BITS-1:0]};
      SZ_BYTE_HI: begin
        if ({1'b0, idx} < HB_LIM)
          field = {{(DATA_W-BYTE_BITS){1'b0}}, src[HALF_BITS-1:BYTE_BITS]};
      end
      default:    field = '0;
    endcase
  end

endmodule

// File: rtl/gpr_subfield_rf.sv
module gpr_subfield_rf
  import gpr_rf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 64,
  parameter int HB_REGS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
  input  logic [2:0]                  wr_size,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [$clog2(NUM_REGS)-1:0] rd0_idx,
  input  logic [2:0]                  rd0_size,
  output logic [DATA_W-1:0]           rd0_data,
  input  logic [$clog2(NUM_REGS)-1:0] rd1_idx,
  input  logic [2:0]                  rd1_size,
  output logic [DATA_W-1:0]           rd1_data,
  output logic                        wr_illegal
);

  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int NUM_RD = 2;

  logic [DATA_W-1:0] rf_q [NUM_REGS];
  logic [DATA_W-1:0] merged;
  logic              wr_legal;
  logic              wr_commit;
  logic [NUM_REGS-1:0] entry_we;
  logic              illegal_d;
  logic              illegal_q;

  // Write path: merge with the current contents of the target entry
  gpr_wr_merge #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .HB_REGS(HB_REGS)
  ) u_merge (
    .old_val(rf_q[wr_idx]),
    .wdata  (wr_data),
    .size   (wr_size),
    .idx    (wr_idx),
    .new_val(merged),
    .legal  (wr_legal)
  );

  assign wr_commit = wr_en & wr_legal;
  assign illegal_d = wr_en & ~wr_legal;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      entry_we[i] = wr_commit && (wr_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) rf_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (entry_we[i]) rf_q[i] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= illegal_d;
  end

  assign wr_illegal = illegal_q;

  // Read ports with write-through bypass
  logic [IDX_W-1:0]  rp_idx  [NUM_RD];
  logic [2:0]        rp_size [NUM_RD];
  logic [DATA_W-1:0] rp_src  [NUM_RD];
  logic [DATA_W-1:0] rp_out  [NUM_RD];

  assign rp_idx[0]  = rd0_idx;
  assign rp_size[0] = rd0_size;
  assign rp_idx[1]  = rd1_idx;
  assign rp_size[1] = rd1_size;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rp_src[p] = (wr_commit && (wr_idx == rp_idx[p])) ? merged
                                                            : rf_q[rp_idx[p]];
    gpr_rd_extract #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .HB_REGS(HB_REGS)
    ) u_ext (
      .src  (rp_src[p]),
      .size (rp_size[p]),
      .idx  (rp_idx[p]),
      .field(rp_out[p])
    );
  end

  assign rd0_data = rp_out[0];
  assign rd1_data = rp_out[1];

  // Assertions
  a_r3_word_clears_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 3'b001) |=> (rf_q[$past(wr_idx)][DATA_W-1:WORD_BITS] == '0));

  a_r4_half_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 3'b010) |=>
      (rf_q[$past(wr_idx)][DATA_W-1:HALF_BITS] == $past(rf_q[wr_idx][DATA_W-1:HALF_BITS])));

  a_r5_lo_byte_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 3'b011) |=>
      (rf_q[$past(wr_idx)][DATA_W-1:BYTE_BITS] == $past(rf_q[wr_idx][DATA_W-1:BYTE_BITS])));

  a_r6_hi_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 3'b100 && wr_legal) |=>
      (rf_q[$past(wr_idx)][HALF_BITS-1:BYTE_BITS] == $past(wr_data[BYTE_BITS-1:0]) &&
       rf_q[$past(wr_idx)][BYTE_BITS-1:0] == $past(rf_q[wr_idx][BYTE_BITS-1:0])));

  a_r7_dropped_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_legal) |=> (rf_q[$past(wr_idx)] == $past(rf_q[wr_idx])));

  a_r7_hb_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 3'b100 && {1'b0, wr_idx} >= (IDX_W+1)'(HB_REGS)) |=> wr_illegal);

  a_r8_bad_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size > 3'b100) |=> wr_illegal);

  a_r10_bypass_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_legal && rd0_idx == wr_idx && rd0_size == 3'b000) |=>
      (rf_q[$past(wr_idx)] == $past(rd0_data)));

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (!wr_illegal && rf_q[$past(wr_idx)] == $past(rf_q[wr_idx])));

endmodule

// File: tb/gpr_subfield_rf_bench.sv
`timescale 1ns/1ps
module gpr_subfield_rf_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [2:0]  wr_size;
  logic [63:0] wr_data;
  logic [3:0]  rd0_idx, rd1_idx;
  logic [2:0]  rd0_size, rd1_size;
  logic [63:0] rd0_data, rd1_data;
  logic        wr_illegal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] model [16];

  always #2.5 clk = ~clk;

  gpr_subfield_rf u_gpr_subfield_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_size(wr_size), .wr_data(wr_data),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
    .wr_illegal(wr_illegal)
  );

  function automatic bit ref_ok(input logic [2:0] s, input logic [3:0] i);
    if (s < 3'd4) return 1'b1;
    if (s == 3'd4) return (i < 4);
    return 1'b0;
  endfunction

  function automatic logic [63:0] ref_merge(input logic [63:0] old,
      input logic [63:0] d, input logic [2:0] s);
    logic [63:0] mask;
    logic [63:0] keep;
    int sh;
    sh = 0;
    case (s)
      3'd0: begin mask = '1;            keep = '0; end
      3'd1: begin mask = 64'hFFFF_FFFF; keep = '0; end
      3'd2: begin mask = 64'hFFFF;      keep = ~mask; end
      3'd3: begin mask = 64'hFF;        keep = ~mask; end
      default: begin mask = 64'hFF00;   keep = ~mask; sh = 8; end
    endcase
    return (old & keep) | ((d << sh) & mask);
  endfunction

  function automatic logic [63:0] ref_read(input logic [63:0] v,
      input logic [2:0] s, input logic [3:0] i);
    case (s)
      3'd0: return v;
      3'd1: return v & 64'hFFFF_FFFF;
      3'd2: return v & 64'hFFFF;
      3'd3: return v & 64'hFF;
      3'd4: return (i < 4) ? ((v >> 8) & 64'hFF) : 64'h0;
      default: return 64'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [3:0] wi, input logic [2:0] ws,
      input logic [63:0] wd, input logic [3:0] i0, input logic [2:0] s0,
      input logic [3:0] i1, input logic [2:0] s1, input string tag);
    logic [63:0] nv;
    logic [63:0] v0, v1;
    bit ok;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
    rd0_idx = i0; rd0_size = s0; rd1_idx = i1; rd1_size = s1;
    ok = ref_ok(ws, wi);
    nv = ref_merge(model[wi], wd, ws);
    v0 = (we && ok && wi == i0) ? nv : model[i0];
    v1 = (we && ok && wi == i1) ? nv : model[i1];
    #1;
    chk((we && ok && wi == i0) ? "R10 port0" : {tag, " port0"}, rd0_data, ref_read(v0, s0, i0));
    chk((we && ok && wi == i1) ? "R10 port1" : "R11 port1", rd1_data, ref_read(v1, s1, i1));
    @(posedge clk);
    if (we && ok) model[wi] = nv;
    #1;
    chk(!we ? "R12 flag" : (ws == 3'd4 ? "R7 flag" : (ws > 3'd4 ? "R8 flag" : "R2 flag")),
        {63'b0, wr_illegal}, {63'b0, we && !ok});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_idx = 0; wr_size = 0; wr_data = 0;
    rd0_idx = 0; rd0_size = 0; rd1_idx = 0; rd1_size = 0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 flag in reset", {63'b0, wr_illegal}, 64'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) step(0, 0, 0, '1, 4'(i), 0, 4'(15 - i), 0, "R1");

    // R6 sequence on entry 0 (R2, R5, R6, R4, R3)
    step(1, 0, 3'd0, 64'h1234567890ABCDEF, 1, 0, 2, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 3, "R2");
    chk("R2 full", rd0_data, 64'h1234567890ABCDEF);
    step(1, 0, 3'd3, 64'hAAAA_AAAA_AAAA_AAFF, 1, 0, 1, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    chk("R5 low byte", rd0_data, 64'h1234567890ABCDFF);
    step(1, 0, 3'd4, 64'h55FF, 1, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R6");
    chk("R6 high byte", rd0_data, 64'h1234567890ABFFFF);
    step(1, 0, 3'd2, 64'h1111_BEEF, 1, 0, 1, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R4");
    chk("R4 half", rd0_data, 64'h1234567890ABBEEF);
    step(1, 0, 3'd1, 64'hFFFF_FFFF_0000_0000, 1, 0, 1, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R3");
    chk("R3 word", rd0_data, 64'h0);

    // R5 on a high index, R7 boundary at index 3 and 4
    step(1, 15, 3'd0, 64'hCAFE_F00D_1234_5678, 15, 0, 0, 0, "R2");
    step(1, 15, 3'd3, 64'h9A, 15, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 15, 0, 0, 0, "R5");
    chk("R5 index 15", rd0_data, 64'hCAFE_F00D_1234_569A);
    step(1, 4, 3'd0, 64'h0123_4567_89AB_CDEF, 4, 0, 3, 0, "R2");
    step(1, 4, 3'd4, 64'h77, 4, 0, 4, 4, "R7");
    step(0, 0, 0, 0, 4, 0, 4, 4, "R7");
    chk("R7 index 4 unchanged", rd0_data, 64'h0123_4567_89AB_CDEF);
    chk("R9 hb read index 4", rd1_data, 64'h0);
    step(1, 3, 3'd4, 64'h77, 3, 0, 3, 4, "R6");
    step(0, 0, 0, 0, 3, 4, 3, 0, "R9");
    chk("R6 index 3 lane", rd0_data, 64'h77);

    // R8 unused codes, R12 idle, R9 read sizes
    for (int c = 5; c < 8; c++) step(1, 4, 3'(c), '1, 4, 0, 4, 3'(c), "R8");
    step(0, 0, 0, 0, 4, 0, 0, 0, "R8");
    chk("R8 unchanged", rd0_data, 64'h0123_4567_89AB_CDEF);
    step(0, 4, 3'd0, 64'hDEAD, 4, 0, 4, 1, "R12");
    step(0, 0, 0, 0, 4, 0, 0, 0, "R12");
    chk("R12 unchanged", rd0_data, 64'h0123_4567_89AB_CDEF);
    for (int s = 0; s < 8; s++) step(0, 0, 0, 0, 4, 3'(s), 15, 3'(s), "R9");

    // R10 and R11 under random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      step(($urandom % 4) != 0, 4'($urandom), 3'($urandom % 6), d,
           4'($urandom), 3'($urandom), 4'($urandom), 3'($urandom), "R11");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule